// File: doc/BRIEF.md
# Radio Transceiver Mode Sequencer

This block sits between a host controller and an external narrow-band radio module. It owns the module's power enable and its two active-low path selects, one for receive and one for transmit. It never lets both selects go active together. Channel changes go through a separate serial loader. The sequencer raises a load request, waits for the loader to finish, and then watches the lock-detect pin. It accepts lock only after lock-detect has stayed high for a run of consecutive ticks, and gives up after a timeout.

The host sends four commands: power-up, set channel, go receive and go transmit. The block tells the host when received data can be trusted and when transmit data may start. At the start of every transmission it gates out an alternating 1010 preamble. Every delay is counted in pulses of a millisecond tick. The first lock after power-up is given a longer settle time than later relocks. A command that arrives while a delay is running is parked in a one-entry slot and executed when the delay ends.

Top module: `radio_mode_seq`

## Requirements
- R1: In reset and until a power-up command (op code 0) is executed, pwr_en is 0, both selects are high and load_req, rx_valid and tx_ready are 0. Set-channel, receive and transmit commands given in this state are discarded.
- R2: tx_sel_n and rx_sel_n are never low in the same cycle.
- R3: A power-up command presented with cmd_valid in cycle k raises pwr_en and lowers rx_sel_n from the second rising edge after k. Power then stays on.
- R4: Set-channel (op code 1) raises load_req with load_chan equal to cmd_chan. Both are held until load_done, and only while the receive select is low. Given during transmit, it lowers rx_sel_n and raises tx_sel_n at the same edge as load_req.
- R5: After load_done, rx_valid rises on the tick that completes the settle wait, provided lock is qualified on that tick. The settle wait is SETTLE_FIRST_MS ticks for the first successful lock after power-up and SETTLE_NEXT_MS ticks afterwards.
- R6: Lock counts as qualified only on a tick where lock_det has been high for LOCK_TICKS consecutive ticks. A low tick restarts the run.
- R7: If lock is not qualified by the LOCK_TIMEOUT_MS-th tick after load_done, lock_fail goes to 1 and the block returns to receive with rx_valid 0. The next set-channel command clears lock_fail.
- R8: A receive command (op code 2) given in transmit, or in receive with a locked channel, raises rx_valid after RX_MS ticks.
- R9: A transmit command (op code 3) in receive with a locked channel swaps the selects at one edge. preamble_en then stays high for max(TX_MS, PREAMBLE_MS) ticks, after which tx_ready rises.
- R10: Transmit and receive commands are discarded while no channel has locked, including after a lock failure.
- R11: Commands arriving during a load, a settle wait or the transmit wait are held and executed once the wait ends. A newer command replaces an older held one.
- R12: preamble_bit is 1 in the first preamble cycle and inverts on every clock while preamble_en is high.
- R13: A power-up command while already powered changes no output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ms_tick | input | 1 | One-cycle pulse per millisecond |
| cmd_valid | input | 1 | Host command strobe |
| cmd_op | input | 2 | Command code: 0 power-up, 1 set channel, 2 receive, 3 transmit |
| cmd_chan | input | CHW | Channel number for set channel |
| load_done | input | 1 | Serial loader finished writing the synthesizer |
| lock_det | input | 1 | Synthesizer lock indicator, high when locked |
| pwr_en | output | 1 | Module power enable |
| tx_sel_n | output | 1 | Transmit path select, active low |
| rx_sel_n | output | 1 | Receive path select, active low |
| load_req | output | 1 | Request to the serial loader |
| load_chan | output | CHW | Channel for the loader |
| rx_valid | output | 1 | Received data may be used |
| tx_ready | output | 1 | Transmit data may be sent |
| preamble_en | output | 1 | Preamble gating active |
| preamble_bit | output | 1 | Alternating preamble data |
| lock_fail | output | 1 | Last channel load failed to lock |

## Verification
The bench shrinks the waits to SETTLE_FIRST_MS=8, SETTLE_NEXT_MS=4, RX_MS=2, TX_MS=2, PREAMBLE_MS=3, LOCK_TICKS=3 and LOCK_TIMEOUT_MS=12, and issues a tick every four clocks. A full power-up, lock, timeout and transmit cycle therefore fits in a few hundred clocks. Because the preamble is longer than the transmit settle, the max() rule is exercised. A lock pattern that toggles and then holds high makes qualification, not settle time, decide the rx_valid edge. Since the timeout is only three settle windows long, the failure path is reached within the same run.

// File: rtl/rms_pkg.sv
package rms_pkg;

  typedef enum logic [2:0] {
    ST_OFF, ST_RXI, ST_LOAD, ST_LWAIT, ST_RXSET, ST_TXWAIT, ST_TXON
  } rms_state_t;

  typedef enum logic [1:0] {
    OP_POWER = 2'd0, OP_CHAN = 2'd1, OP_RX = 2'd2, OP_TX = 2'd3
  } rms_op_t;

  function automatic int unsigned max2(int unsigned a, int unsigned b);
    return (a > b) ? a : b;
  endfunction

  // settle length picked by whether a lock has ever succeeded since power-up
  function automatic int unsigned settle_len(logic first, int unsigned f, int unsigned n);
    return first ? f : n;
  endfunction

  // transmit wait covers both the path settle and the preamble
  function automatic int unsigned tx_wait_len(int unsigned settle, int unsigned pre);
    return max2(settle, pre);
  endfunction

endpackage

// File: rtl/rms_cmd_slot.sv
module rms_cmd_slot #(
  parameter int CHW = 8
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           in_valid,
  input  logic [1:0]     in_op,
  input  logic [CHW-1:0] in_chan,
  input  logic           take,
  output logic           slot_v,
  output logic [1:0]     slot_op,
  output logic [CHW-1:0] slot_chan
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      slot_v    <= 1'b0;
      slot_op   <= 2'd0;
      slot_chan <= '0;
    end else if (in_valid) begin
      slot_v    <= 1'b1;
      slot_op   <= in_op;
      slot_chan <= in_chan;
    end else if (take) begin
      slot_v <= 1'b0;
    end
  end
endmodule

// File: rtl/rms_tick_timer.sv
module rms_tick_timer #(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          tick,
  output logic [CW-1:0] cnt_nxt
);
  logic [CW-1:0] cnt_q;
  logic          full;

  assign full    = &cnt_q;
  assign cnt_nxt = full ? cnt_q : cnt_q + CW'(1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    cnt_q <= '0;
    else if (clr)  cnt_q <= '0;
    else if (tick) cnt_q <= cnt_nxt;
  end
endmodule

// File: rtl/rms_lock_qual.sv
module rms_lock_qual #(
  parameter int NEED = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic tick,
  input  logic lock,
  output logic lock_ok
);
  localparam int RW = $clog2(NEED + 1) + 1;
  localparam logic [RW:0] NEED_V = (RW+1)'(NEED);

  logic [RW-1:0] run_q;
  logic [RW:0]   run_inc;

  assign run_inc = {1'b0, run_q} + (RW+1)'(1);
  assign lock_ok = tick & lock & (run_inc >= NEED_V);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      run_q <= '0;
    else if (clr)    run_q <= '0;
    else if (tick) begin
      if (!lock)                     run_q <= '0;
      else if (run_inc <= NEED_V)    run_q <= run_inc[RW-1:0];
    end
  end
endmodule

// File: rtl/rms_preamble.sv
module rms_preamble (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  output logic pre_bit
);
  logic bit_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   bit_q <= 1'b1;
    else if (!en) bit_q <= 1'b1;
    else          bit_q <= ~bit_q;
  end

  assign pre_bit = en & bit_q;
endmodule

// File: rtl/radio_mode_seq.sv
module radio_mode_seq
  import rms_pkg::*;
#(
  parameter int CHW             = 8,
  parameter int SETTLE_FIRST_MS = 40,
  parameter int SETTLE_NEXT_MS  = 20,
  parameter int RX_MS           = 5,
  parameter int TX_MS           = 5,
  parameter int PREAMBLE_MS     = 15,
  parameter int LOCK_TICKS      = 4,
  parameter int LOCK_TIMEOUT_MS = 60
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           ms_tick,
  input  logic           cmd_valid,
  input  logic [1:0]     cmd_op,
  input  logic [CHW-1:0] cmd_chan,
  input  logic           load_done,
  input  logic           lock_det,
  output logic           pwr_en,
  output logic           tx_sel_n,
  output logic           rx_sel_n,
  output logic           load_req,
  output logic [CHW-1:0] load_chan,
  output logic           rx_valid,
  output logic           tx_ready,
  output logic           preamble_en,
  output logic           preamble_bit,
  output logic           lock_fail
);
  localparam int unsigned TXLEN  = tx_wait_len(TX_MS, PREAMBLE_MS);
  localparam int unsigned MAXLEN = max2(max2(LOCK_TIMEOUT_MS, SETTLE_FIRST_MS),
                                        max2(TXLEN, max2(RX_MS, SETTLE_NEXT_MS)));
  localparam int CW = $clog2(MAXLEN + 1) + 1;
  localparam logic [CW-1:0] L_RX = CW'(RX_MS);
  localparam logic [CW-1:0] L_TX = CW'(TXLEN);
  localparam logic [CW-1:0] L_TO = CW'(LOCK_TIMEOUT_MS);

  rms_state_t     state, st_n;
  logic           rxv_q, rxv_n, ok_q, ok_n, first_q, first_n, fail_q, fail_n;
  logic [CHW-1:0] chan_q, chan_n;
  logic           take, restart, lock_ok;
  logic           slot_v;
  logic [1:0]     slot_op;
  logic [CHW-1:0] slot_chan;
  logic [CW-1:0]  cnt_nxt, settle;
  rms_op_t        op;

  // events brought out for the checker
  logic in_lwait;
  assign in_lwait = (state == ST_LWAIT);

  rms_cmd_slot #(.CHW(CHW)) u_slot (
    .clk(clk), .rst_n(rst_n), .in_valid(cmd_valid), .in_op(cmd_op),
    .in_chan(cmd_chan), .take(take), .slot_v(slot_v), .slot_op(slot_op),
    .slot_chan(slot_chan)
  );

  rms_tick_timer #(.CW(CW)) u_tmr (
    .clk(clk), .rst_n(rst_n), .clr(restart), .tick(ms_tick), .cnt_nxt(cnt_nxt)
  );

  rms_lock_qual #(.NEED(LOCK_TICKS)) u_lq (
    .clk(clk), .rst_n(rst_n), .clr(restart), .tick(ms_tick), .lock(lock_det),
    .lock_ok(lock_ok)
  );

  rms_preamble u_pre (
    .clk(clk), .rst_n(rst_n), .en(preamble_en), .pre_bit(preamble_bit)
  );

  assign op      = rms_op_t'(slot_op);
  assign settle  = CW'(settle_len(first_q, SETTLE_FIRST_MS, SETTLE_NEXT_MS));
  assign restart = (st_n != state);

  always_comb begin
    st_n    = state;
    rxv_n   = rxv_q;
    ok_n    = ok_q;
    first_n = first_q;
    fail_n  = fail_q;
    chan_n  = chan_q;
    take    = 1'b0;
    unique case (state)
      ST_OFF: begin
        if (slot_v) begin
          take = 1'b1;
          if (op == OP_POWER) begin
            st_n    = ST_RXI;
            first_n = 1'b1;
            ok_n    = 1'b0;
            rxv_n   = 1'b0;
          end
        end
      end
      ST_RXI, ST_TXON: begin
        if (slot_v) begin
          take = 1'b1;
          unique case (op)
            OP_CHAN: begin
              st_n   = ST_LOAD;
              chan_n = slot_chan;
              rxv_n  = 1'b0;
              ok_n   = 1'b0;
              fail_n = 1'b0;
            end
            OP_RX: begin
              if (ok_q) begin
                st_n  = ST_RXSET;
                rxv_n = 1'b0;
              end
            end
            OP_TX: begin
              if (ok_q && state == ST_RXI) begin
                st_n  = ST_TXWAIT;
                rxv_n = 1'b0;
              end
            end
            default: ;
          endcase
        end
      end
      ST_LOAD: begin
        if (load_done) st_n = ST_LWAIT;
      end
      ST_LWAIT: begin
        if (lock_ok && cnt_nxt >= settle) begin
          st_n    = ST_RXI;
          rxv_n   = 1'b1;
          ok_n    = 1'b1;
          first_n = 1'b0;
        end else if (ms_tick && cnt_nxt >= L_TO) begin
          st_n   = ST_RXI;
          fail_n = 1'b1;
        end
      end
      ST_RXSET: begin
        if (ms_tick && cnt_nxt >= L_RX) begin
          st_n  = ST_RXI;
          rxv_n = 1'b1;
        end
      end
      ST_TXWAIT: begin
        if (ms_tick && cnt_nxt >= L_TX) st_n = ST_TXON;
      end
      default: st_n = ST_OFF;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= ST_OFF;
      rxv_q   <= 1'b0;
      ok_q    <= 1'b0;
      first_q <= 1'b1;
      fail_q  <= 1'b0;
      chan_q  <= '0;
    end else begin
      state   <= st_n;
      rxv_q   <= rxv_n;
      ok_q    <= ok_n;
      first_q <= first_n;
      fail_q  <= fail_n;
      chan_q  <= chan_n;
    end
  end

  assign pwr_en      = (state != ST_OFF);
  assign rx_sel_n    = !(state inside {ST_RXI, ST_LOAD, ST_LWAIT, ST_RXSET});
  assign tx_sel_n    = !(state inside {ST_TXWAIT, ST_TXON});
  assign load_req    = (state == ST_LOAD);
  assign load_chan   = chan_q;
  assign rx_valid    = (state == ST_RXI) && rxv_q;
  assign tx_ready    = (state == ST_TXON);
  assign preamble_en = (state == ST_TXWAIT);
  assign lock_fail   = fail_q;

endmodule

// File: rtl/rms_checker.sv
module rms_checker #(
  parameter int CHW = 8
) (
  input logic           clk,
  input logic           rst_n,
  input logic           ms_tick,
  input logic           lock_det,
  input logic           load_done,
  input logic           pwr_en,
  input logic           tx_sel_n,
  input logic           rx_sel_n,
  input logic           load_req,
  input logic [CHW-1:0] load_chan,
  input logic           rx_valid,
  input logic           tx_ready,
  input logic           preamble_en,
  input logic           preamble_bit,
  input logic           lock_fail,
  input logic           in_lwait
);
  assert_off_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !pwr_en |-> (tx_sel_n && rx_sel_n && !load_req && !rx_valid && !tx_ready));

  assert_sel_excl_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_sel_n || rx_sel_n));

  assert_power_holds_R3: assert property (@(posedge clk) disable iff (!rst_n)
    pwr_en |=> pwr_en);

  assert_load_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (load_req && !load_done) |=> (load_req && $stable(load_chan)));

  assert_load_in_rx_R4: assert property (@(posedge clk) disable iff (!rst_n)
    load_req |-> (!rx_sel_n && tx_sel_n));

  assert_valid_in_rx_R5: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |-> (!rx_sel_n && !load_req && !lock_fail));

  assert_valid_lock_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(rx_valid) && $past(in_lwait)) |-> $past(lock_det && ms_tick));

  assert_fail_rx_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(lock_fail) |-> (!rx_valid && !rx_sel_n && !load_req));

  assert_ready_tx_R9: assert property (@(posedge clk) disable iff (!rst_n)
    tx_ready |-> (!tx_sel_n && !preamble_en));

  assert_pre_alt_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (preamble_en && $past(preamble_en)) |-> (preamble_bit != $past(preamble_bit)));
endmodule

bind radio_mode_seq rms_checker #(.CHW(CHW)) u_chk (
  .clk(clk), .rst_n(rst_n), .ms_tick(ms_tick), .lock_det(lock_det),
  .load_done(load_done), .pwr_en(pwr_en), .tx_sel_n(tx_sel_n),
  .rx_sel_n(rx_sel_n), .load_req(load_req), .load_chan(load_chan),
  .rx_valid(rx_valid), .tx_ready(tx_ready), .preamble_en(preamble_en),
  .preamble_bit(preamble_bit), .lock_fail(lock_fail), .in_lwait(in_lwait)
);

// File: tb/sim_radio_mode_seq.sv
`timescale 1ns/1ps
module sim_radio_mode_seq;
  localparam int CHW = 8;
  localparam int SF = 8, SN = 4, RXW = 2, TXW = 2, PRE = 3, LKN = 3, LTO = 12;
  localparam int TXL = (TXW > PRE) ? TXW : PRE;
  localparam int MOFF = 0, MRX = 1, MLD = 2, MLW = 3, MRS = 4, MTW = 5, MTA = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ms_tick = 1'b0, cmd_valid = 1'b0, load_done = 1'b0, lock_det = 1'b0;
  logic [1:0] cmd_op = 2'd0;
  logic [CHW-1:0] cmd_chan = '0;
  logic pwr_en, tx_sel_n, rx_sel_n, load_req, rx_valid, tx_ready;
  logic preamble_en, preamble_bit, lock_fail;
  logic [CHW-1:0] load_chan;

  int checks = 0, fails = 0;

  always #2 clk = ~clk;

  radio_mode_seq #(.CHW(CHW), .SETTLE_FIRST_MS(SF), .SETTLE_NEXT_MS(SN),
    .RX_MS(RXW), .TX_MS(TXW), .PREAMBLE_MS(PRE), .LOCK_TICKS(LKN),
    .LOCK_TIMEOUT_MS(LTO)) u0 (
    .clk(clk), .rst_n(rst_n), .ms_tick(ms_tick), .cmd_valid(cmd_valid),
    .cmd_op(cmd_op), .cmd_chan(cmd_chan), .load_done(load_done),
    .lock_det(lock_det), .pwr_en(pwr_en), .tx_sel_n(tx_sel_n),
    .rx_sel_n(rx_sel_n), .load_req(load_req), .load_chan(load_chan),
    .rx_valid(rx_valid), .tx_ready(tx_ready), .preamble_en(preamble_en),
    .preamble_bit(preamble_bit), .lock_fail(lock_fail));

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  // millisecond tick every fourth clock
  int tdiv = 0;
  always @(negedge clk) begin
    tdiv    <= (tdiv == 3) ? 0 : tdiv + 1;
    ms_tick <= rst_n && (tdiv == 3);
  end

  // serial loader stand-in: finishes three cycles after a request
  int ld_cnt = 0;
  always @(negedge clk) begin
    if (!rst_n) begin
      load_done <= 1'b0;
      ld_cnt    <= 0;
    end else begin
      load_done <= 1'b0;
      if (load_req && !load_done && ld_cnt == 0) ld_cnt <= 3;
      else if (ld_cnt == 1) begin load_done <= 1'b1; ld_cnt <= 0; end
      else if (ld_cnt > 1) ld_cnt <= ld_cnt - 1;
    end
  end

  // behavioural reference, advanced at every rising edge
  int m_mode, m_rxv, m_ok, m_first, m_fail, m_ch, m_cnt, m_run, m_pb;
  int p_v, p_op, p_ch, nm, tk, c1, r1;
  always @(posedge clk) begin
    if (!rst_n) begin
      m_mode = MOFF; m_rxv = 0; m_ok = 0; m_first = 1; m_fail = 0; m_ch = 0;
      m_cnt = 0; m_run = 0; m_pb = 1; p_v = 0; p_op = 0; p_ch = 0;
    end else begin
      nm = m_mode; tk = 0;
      c1 = m_cnt + 1;
      r1 = lock_det ? ((m_run + 1 > LKN) ? LKN : m_run + 1) : 0;
      m_pb = (m_mode == MTW) ? (1 - m_pb) : 1;
      if (m_mode == MOFF) begin
        if (p_v != 0) begin
          tk = 1;
          if (p_op == 0) begin nm = MRX; m_first = 1; m_ok = 0; m_rxv = 0; end
        end
      end else if (m_mode == MRX || m_mode == MTA) begin
        if (p_v != 0) begin
          tk = 1;
          if (p_op == 1) begin nm = MLD; m_ch = p_ch; m_rxv = 0; m_ok = 0; m_fail = 0; end
          else if (p_op == 2 && m_ok != 0) begin nm = MRS; m_rxv = 0; end
          else if (p_op == 3 && m_ok != 0 && m_mode == MRX) begin nm = MTW; m_rxv = 0; end
        end
      end else if (m_mode == MLD) begin
        if (load_done) nm = MLW;
      end else if (m_mode == MLW) begin
        if (ms_tick && c1 >= (m_first != 0 ? SF : SN) && r1 >= LKN) begin
          nm = MRX; m_rxv = 1; m_ok = 1; m_first = 0;
        end else if (ms_tick && c1 >= LTO) begin
          nm = MRX; m_fail = 1;
        end
      end else if (m_mode == MRS) begin
        if (ms_tick && c1 >= RXW) begin nm = MRX; m_rxv = 1; end
      end else if (m_mode == MTW) begin
        if (ms_tick && c1 >= TXL) nm = MTA;
      end
      if (nm != m_mode) begin m_cnt = 0; m_run = 0; end
      else if (ms_tick) begin m_cnt = c1; m_run = r1; end
      if (cmd_valid) begin p_v = 1; p_op = int'(cmd_op); p_ch = int'(cmd_chan); end
      else if (tk != 0) p_v = 0;
      m_mode = nm;
    end
  end

  // every-cycle comparison against the reference
  always @(negedge clk) begin
    if (rst_n) begin
      chk(pwr_en == (m_mode != MOFF), "R3 pwr_en", pwr_en, m_mode != MOFF);
      chk(rx_sel_n == !(m_mode >= MRX && m_mode <= MRS), "R2 rx_sel_n", rx_sel_n,
          !(m_mode >= MRX && m_mode <= MRS));
      chk(tx_sel_n == !(m_mode == MTW || m_mode == MTA), "R2 tx_sel_n", tx_sel_n,
          !(m_mode == MTW || m_mode == MTA));
      chk(load_req == (m_mode == MLD), "R4 load_req", load_req, m_mode == MLD);
      chk(int'(load_chan) == m_ch, "R4 load_chan", load_chan, m_ch);
      chk(rx_valid == (m_mode == MRX && m_rxv != 0), "R5 rx_valid", rx_valid,
          m_mode == MRX && m_rxv != 0);
      chk(tx_ready == (m_mode == MTA), "R9 tx_ready", tx_ready, m_mode == MTA);
      chk(preamble_en == (m_mode == MTW), "R9 preamble_en", preamble_en, m_mode == MTW);
      chk(preamble_bit == (m_mode == MTW && m_pb != 0), "R12 preamble_bit",
          preamble_bit, m_mode == MTW && m_pb != 0);
      chk(lock_fail == (m_fail != 0), "R7 lock_fail", lock_fail, m_fail);
    end
  end

  task automatic send(input int op, input int ch);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_op = 2'(op); cmd_chan = CHW'(ch);
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // ticks from load_done until rx_valid or lock_fail; lock follows a pattern
  task automatic settle_ticks(input int hold_from, output int t);
    int guard = 0;
    t = 0;
    while (!load_done && guard < 500) begin @(negedge clk); guard++; end
    while (guard < 2000) begin
      @(negedge clk); guard++;
      if (ms_tick) t++;
      if (rx_valid || lock_fail) break;
      if (t < hold_from) lock_det = (hold_from < 100) ? t[0] : 1'b0;
      else lock_det = 1'b1;
    end
  endtask

  task automatic ticks_until_tx(output int t);
    t = 0;
    for (int g = 0; g < 500; g++) begin
      @(negedge clk);
      if (ms_tick) t++;
      if (tx_ready) break;
    end
  endtask

  task automatic ticks_until_rx(output int t);
    t = 0;
    for (int g = 0; g < 500; g++) begin
      @(negedge clk);
      if (ms_tick) t++;
      if (rx_valid) break;
    end
  endtask

  initial begin
    int t;
    repeat (4) @(negedge clk);
    chk(!pwr_en && tx_sel_n && rx_sel_n && !load_req && !rx_valid && !tx_ready,
        "R1 reset state", pwr_en, 0);
    rst_n = 1'b1;
    // R1: commands other than power-up ignored while off
    send(2, 0); send(3, 0); send(1, 3);
    idle(6);
    chk(!pwr_en && tx_sel_n && rx_sel_n && !load_req, "R1 off ignores", load_req, 0);
    // R3: power-up
    send(0, 0);
    @(negedge clk);
    chk(pwr_en && !rx_sel_n && tx_sel_n, "R3 power-up", pwr_en, 1);
    // R10: transmit with no channel is dropped
    send(3, 0); idle(6);
    chk(tx_sel_n == 1'b1, "R10 tx without channel", tx_sel_n, 1);
    // R5: first lock
    lock_det = 1'b1;
    send(1, 5);
    @(negedge clk);
    chk(load_req && load_chan == 8'd5, "R4 load request", load_chan, 5);
    settle_ticks(0, t);
    chk(t == SF, "R5 first settle ticks", t, SF);
    // R13: power-up while powered changes nothing
    send(0, 0); idle(4);
    chk(pwr_en && rx_valid && !rx_sel_n && !load_req, "R13 power-up ignored", rx_valid, 1);
    // R5: later lock uses the shorter settle
    send(1, 9);
    settle_ticks(0, t);
    chk(t == SN, "R5 later settle ticks", t, SN);
    // R6: toggling lock then steady high: qualified at tick 5+3
    send(1, 10);
    settle_ticks(5, t);
    chk(t == 8, "R6 glitch qualification ticks", t, 8);
    // R7: lock never comes
    send(1, 11);
    settle_ticks(1000, t);
    chk(t == LTO && lock_fail && !rx_valid && !rx_sel_n, "R7 timeout ticks", t, LTO);
    send(3, 0); idle(8);
    chk(tx_sel_n == 1'b1, "R10 tx after lock failure", tx_sel_n, 1);
    send(2, 0); idle(8);
    chk(rx_valid == 1'b0, "R10 rx after lock failure", rx_valid, 0);
    // R7: next channel clears the flag
    lock_det = 1'b1;
    send(1, 12);
    @(negedge clk);
    chk(lock_fail == 1'b0, "R7 flag cleared", lock_fail, 0);
    settle_ticks(0, t);
    chk(t == SN, "R5 settle after failure", t, SN);
    // R9/R12: transmit
    send(3, 0);
    @(negedge clk);
    chk(!tx_sel_n && rx_sel_n && preamble_en && preamble_bit, "R9 tx entry", tx_sel_n, 0);
    ticks_until_tx(t);
    chk(t == TXL, "R9 tx wait ticks", t, TXL);
    // R4: channel change from transmit falls back to receive
    send(1, 20);
    @(negedge clk);
    chk(load_req && !rx_sel_n && tx_sel_n && load_chan == 8'd20, "R4 chan from tx",
        rx_sel_n, 0);
    // R11: held commands, newer replaces older
    send(2, 0); send(3, 0);
    chk(tx_sel_n == 1'b1, "R11 tx held during wait", tx_sel_n, 1);
    ticks_until_tx(t);
    chk(tx_ready == 1'b1, "R11 held tx executed", tx_ready, 1);
    // R8: receive from transmit
    send(2, 0);
    @(negedge clk);
    ticks_until_rx(t);
    chk(t == RXW && rx_valid, "R8 rx settle ticks", t, RXW);
    idle(4);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog R11 actual=%0d expected=%0d", 0, 1);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule